// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block connects a simple register bus to an 8-bit NAND flash bus with two chip enables. Software selects the kind of flash bus cycle by the port it writes. A command byte goes out with the command latch enable (CLE) high. An address byte goes out with the address latch enable (ALE) high. A data byte goes out with both latches low. Reading the data port produces a read strobe and returns the byte present on the flash bus when the strobe rises.

Each flash bus cycle has a setup phase, a strobe-low phase and a hold phase. Software sets the length of each phase in its own timing register. The register bus stays stalled until the cycle has finished. Both chip enables, the write-protect pin and a controller-enable bit are held in one control register. The ready/busy pin of the flash passes through a two-flop synchroniser and then appears in a status register.

Top module: `nfc_bus_ctrl`

Register offsets on `reg_addr`: 0 control, 1 command port, 2 address port, 3 data port, 4 status, 5 setup count, 6 strobe count, 7 hold count. Control bits: bit 0 controller enable, bit 1 chip-0 enable (active low), bit 2 chip-1 enable (active low), bit 3 write protect. Bits 7:4 read as zero.

## Requirements
- R1: After reset the control register reads 0x07: enabled, both chips deselected, write protect off. At reset `fl_ce_n` is 2'b11, `fl_wp_n` is 1, both strobes are high and CLE and ALE are low. The timing registers reset to setup 1, strobe 2 and hold 1.
- R2: `fl_ce_n[0]` follows control bit 1 and `fl_ce_n[1]` follows control bit 2. Clearing only one of these bits selects only that chip, and the enables do not change during a bus cycle.
- R3: A write to offset 1 produces one `fl_we_n` pulse. While the pulse is low, `fl_dout` carries the byte, CLE is 1 and ALE is 0. CLE and ALE are never high together.
- R4: A write to offset 2 produces one `fl_we_n` pulse. While the pulse is low, `fl_dout` carries the byte, ALE is 1 and CLE is 0.
- R5: A write to offset 3 produces one `fl_we_n` pulse with the byte on `fl_dout`, and CLE and ALE both low.
- R6: A read of offset 3 produces one `fl_re_n` pulse. `reg_rdata` returns the value `fl_din` had on the clock edge at which `fl_re_n` rises.
- R7: With setup count S, strobe count P and hold count H (bits 3:0 of offsets 5, 6 and 7), the strobe stays low for P+1 clocks. `reg_ack` comes S+P+H+3 clocks after the request is presented. `fl_we_n` and `fl_re_n` are never low together.
- R8: Bit 0 of the status register at offset 4 shows `fl_rb` after two clock edges, with 1 meaning ready. A change is not visible after a single edge.
- R9: While control bit 3 is set, `fl_wp_n` is 0. While it is clear, `fl_wp_n` is 1.
- R10: While control bit 0 is clear, an access to a port is acknowledged in the same cycle and produces no strobe.
- R11: An access to the control, status or timing registers is acknowledged in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with `reg_ack` |
| reg_ack | output | 1 | Access complete |
| fl_ce_n | output | 2 | Chip enables, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_wp_n | output | 1 | Write protect, active low |
| fl_dout | output | 8 | Flash bus output byte |
| fl_doe | output | 1 | Output enable for `fl_dout` |
| fl_din | input | 8 | Flash bus input byte |
| fl_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
A table of port writes covers the command, address and data ports with data bytes of different bit patterns. The table shows whether the right latch line travels with each byte and whether bytes reach the bus unchanged. The strobe width and the acknowledge delay are measured at the reset timing, at all-zero counts and at large counts. This tells an off-by-one error in any single phase apart from an error in the phase sequence. Directed cases select each chip and toggle write protect. They also disable the controller and read two different flash bytes. A ready/busy step is sampled one edge and two edges after it occurs, which shows whether the synchroniser has the right depth.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_CMD  = 3'd1;
  localparam logic [2:0] OFS_ADR  = 3'd2;
  localparam logic [2:0] OFS_DAT  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam logic [2:0] OFS_TSET = 3'd5;
  localparam logic [2:0] OFS_TPUL = 3'd6;
  localparam logic [2:0] OFS_THLD = 3'd7;

  localparam int CB_EN  = 0;
  localparam int CB_CE0 = 1;
  localparam int CB_CE1 = 2;
  localparam int CB_WP  = 3;
  localparam int CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0111;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;
endpackage

// File: rtl/nfc_sync2.sv
module nfc_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {2{RST_VAL}};
    else        stg_q <= {stg_q[0], d_in};
  end

  assign d_out = stg_q[1];
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter logic [CNT_W-1:0] TS_RST = 1,
  parameter logic [CNT_W-1:0] TP_RST = 2,
  parameter logic [CNT_W-1:0] TH_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  t_setup,
  output logic [CNT_W-1:0]  t_pulse,
  output logic [CNT_W-1:0]  t_hold
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [CNT_W-1:0]  ts_d, tp_d, th_d;

  always_comb begin
    ctrl_d = ctrl;
    ts_d   = t_setup;
    tp_d   = t_pulse;
    th_d   = t_hold;
    if (wr_en) begin
      case (wr_ofs)
        OFS_CTRL: ctrl_d = wr_data[CTRL_W-1:0];
        OFS_TSET: ts_d   = wr_data[CNT_W-1:0];
        OFS_TPUL: tp_d   = wr_data[CNT_W-1:0];
        OFS_THLD: th_d   = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RST;
      t_setup <= TS_RST;
      t_pulse <= TP_RST;
      t_hold  <= TH_RST;
    end else if (wr_en) begin
      ctrl    <= ctrl_d;
      t_setup <= ts_d;
      t_pulse <= tp_d;
      t_hold  <= th_d;
    end
  end
endmodule

// File: rtl/nfc_strobe_seq.sv
module nfc_strobe_seq
  import nfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_read,
  input  logic              op_cle,
  input  logic              op_ale,
  input  logic [DATA_W-1:0] op_data,
  input  logic [CNT_W-1:0]  t_setup,
  input  logic [CNT_W-1:0]  t_pulse,
  input  logic [CNT_W-1:0]  t_hold,
  input  logic [DATA_W-1:0] bus_din,
  output logic              busy,
  output logic              done,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              doe,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rd_byte
);
  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rd_q, cle_q, ale_q;
  logic [DATA_W-1:0] dat_q;
  logic              cap_en;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cap_en = 1'b0;
    case (ph_q)
      PH_IDLE:  if (start) begin ph_d = PH_SETUP; cnt_d = t_setup; end
      PH_SETUP: if (cnt_q == '0) begin ph_d = PH_PULSE; cnt_d = t_pulse; end
                else cnt_d = cnt_q - 1'b1;
      PH_PULSE: if (cnt_q == '0) begin
                  ph_d = PH_HOLD; cnt_d = t_hold; cap_en = rd_q;
                end else cnt_d = cnt_q - 1'b1;
      PH_HOLD:  if (cnt_q == '0) ph_d = PH_IDLE;
                else cnt_d = cnt_q - 1'b1;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      cle_q <= 1'b0;
      ale_q <= 1'b0;
      dat_q <= '0;
    end else if (start && ph_q == PH_IDLE) begin
      rd_q  <= op_read;
      cle_q <= op_cle;
      ale_q <= op_ale;
      dat_q <= op_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_byte <= '0;
    else if (cap_en) rd_byte <= bus_din;
  end

  assign busy = (ph_q != PH_IDLE);
  assign done = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign cle  = busy && cle_q;
  assign ale  = busy && ale_q;
  assign we_n = !((ph_q == PH_PULSE) && !rd_q);
  assign re_n = !((ph_q == PH_PULSE) && rd_q);
  assign doe  = busy && !rd_q;
  assign dout = dat_q;

  // R7: never both strobes low
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R7: a low strobe with count left stays low on the next clock
  a_r7_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && cnt_q != '0) |=> !we_n);
  // R6: captured byte is the bus value at the strobe-rising edge
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!re_n && cnt_q == '0) |=> (re_n && rd_byte == $past(bus_din)));
endmodule

// File: rtl/nfc_bus_ctrl.sv
module nfc_bus_ctrl
  import nfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_ack,
  output logic [1:0]        fl_ce_n,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic              fl_wp_n,
  output logic [DATA_W-1:0] fl_dout,
  output logic              fl_doe,
  input  logic [DATA_W-1:0] fl_din,
  input  logic              fl_rb
);
  logic [1:0]        rst_sync_q;
  logic              rst_in_n;
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  t_setup, t_pulse, t_hold;
  logic              busy, done, rb_sync;
  logic              go, is_port, is_xfer, start, reg_wen;
  logic [DATA_W-1:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  assign go      = reg_req && !busy;
  assign is_port = (reg_addr == OFS_CMD) || (reg_addr == OFS_ADR) || (reg_addr == OFS_DAT);
  assign is_xfer = reg_wr ? is_port : (reg_addr == OFS_DAT);
  assign start   = go && is_xfer && ctrl[CB_EN];
  assign reg_wen = go && reg_wr && !is_port;
  assign reg_ack = (go && !start) || done;

  nfc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_in_n), .wr_en(reg_wen), .wr_ofs(reg_addr),
    .wr_data(reg_wdata), .ctrl(ctrl), .t_setup(t_setup),
    .t_pulse(t_pulse), .t_hold(t_hold));

  nfc_sync2 #(.RST_VAL(1'b1)) rb_sync_i (
    .clk(clk), .rst_n(rst_in_n), .d_in(fl_rb), .d_out(rb_sync));

  nfc_strobe_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_in_n), .start(start), .op_read(!reg_wr),
    .op_cle(reg_addr == OFS_CMD), .op_ale(reg_addr == OFS_ADR),
    .op_data(reg_wdata), .t_setup(t_setup), .t_pulse(t_pulse),
    .t_hold(t_hold), .bus_din(fl_din), .busy(busy), .done(done),
    .cle(fl_cle), .ale(fl_ale), .we_n(fl_we_n), .re_n(fl_re_n),
    .doe(fl_doe), .dout(fl_dout), .rd_byte(rd_byte));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
      OFS_DAT:  reg_rdata = rd_byte;
      OFS_STAT: reg_rdata[0] = rb_sync;
      OFS_TSET: reg_rdata[CNT_W-1:0] = t_setup;
      OFS_TPUL: reg_rdata[CNT_W-1:0] = t_pulse;
      OFS_THLD: reg_rdata[CNT_W-1:0] = t_hold;
      default: ;
    endcase
  end

  assign fl_ce_n = {ctrl[CB_CE1], ctrl[CB_CE0]};
  assign fl_wp_n = !ctrl[CB_WP];

  // R3: the two latch lines are never high together
  a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_in_n)
    !(fl_cle && fl_ale));
  // R2: chip enables stay fixed during a bus cycle
  a_r2_ce_stable: assert property (@(posedge clk) disable iff (!rst_in_n)
    busy |=> $stable(fl_ce_n));
  // R10: a disabled controller drives no strobe
  a_r10_no_strobe_off: assert property (@(posedge clk) disable iff (!rst_in_n)
    !ctrl[CB_EN] |-> (fl_we_n && fl_re_n));
  // R11: register accesses never wait
  a_r11_reg_ack: assert property (@(posedge clk) disable iff (!rst_in_n)
    (reg_req && !busy && !is_port) |-> reg_ack);
endmodule

// File: tb/nfc_bus_ctrl_tb_top.sv
module nfc_bus_ctrl_tb_top;
  localparam int CLK_PER = 10;
  localparam int NVEC = 6;
  // {offset[12:10], byte[9:2], cle[1], ale[0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd1, 8'h70, 1'b1, 1'b0},
    {3'd2, 8'h3C, 1'b0, 1'b1},
    {3'd3, 8'hFF, 1'b0, 1'b0},
    {3'd1, 8'h00, 1'b1, 1'b0},
    {3'd2, 8'hA5, 1'b0, 1'b1},
    {3'd3, 8'h5A, 1'b0, 1'b0}};

  logic       clk = 0, rst_n = 0;
  logic       reg_req = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, fl_dout, fl_din = 0;
  logic       reg_ack, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_wp_n, fl_doe;
  logic       fl_rb = 1;
  logic [1:0] fl_ce_n;

  int n_chk = 0, n_bad = 0;
  int we_run = 0, re_run = 0, we_w = 0, re_w = 0, we_cnt = 0;
  logic [7:0] cap_dout;
  logic cap_cle, cap_ale;
  logic [7:0] rd;
  int waits;

  nfc_bus_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ack(reg_ack), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
    .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_wp_n(fl_wp_n), .fl_dout(fl_dout),
    .fl_doe(fl_doe), .fl_din(fl_din), .fl_rb(fl_rb));

  always #(CLK_PER/2) clk = ~clk;

  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (we_run == 0) we_cnt++;
      we_run++; cap_dout = fl_dout; cap_cle = fl_cle; cap_ale = fl_ale;
    end else if (we_run != 0) begin we_w = we_run; we_run = 0; end
    if (!fl_re_n) re_run++;
    else if (re_run != 0) begin re_w = re_run; re_run = 0; end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xact(input logic wr, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_req = 1; reg_wr = wr; reg_addr = a; reg_wdata = d;
    waits = 0;
    #1;
    while (!reg_ack && waits < 1000) begin @(negedge clk); #1; waits++; end
    rd = reg_rdata;
    @(posedge clk); #1;
    reg_req = 0;
  endtask

  initial begin
    #(CLK_PER * 40000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pulses;
    #(CLK_PER * 2 + 3);
    // R1 reset state at the pins
    check("R1 ce_n", fl_ce_n, 2'b11);
    check("R1 wp_n", fl_wp_n, 1);
    check("R1 strobes", {fl_we_n, fl_re_n}, 2'b11);
    check("R1 cle/ale", {fl_cle, fl_ale}, 2'b00);
    rst_n = 1;
    repeat (3) @(posedge clk);
    xact(0, 3'd0, 0); check("R1 ctrl", rd, 8'h07);
    check("R11 reg ack wait", waits, 0);
    xact(0, 3'd6, 0); check("R1 strobe count", rd, 2);

    // vector table: port writes at reset timing (S=1,P=2,H=1)
    for (int i = 0; i < NVEC; i++) begin
      xact(1, VEC[i][12:10], VEC[i][9:2]);
      check("R3/R4/R5 byte", cap_dout, VEC[i][9:2]);
      check("R3/R4/R5 cle", cap_cle, VEC[i][1]);
      check("R3/R4/R5 ale", cap_ale, VEC[i][0]);
      check("R7 width", we_w, 3);
      check("R7 ack delay", waits, 7);
    end

    // R7 zero and large counts
    xact(1, 3'd5, 0); xact(1, 3'd6, 0); xact(1, 3'd7, 0);
    xact(1, 3'd3, 8'h11);
    check("R7 min width", we_w, 1); check("R7 min delay", waits, 3);
    xact(1, 3'd5, 3); xact(1, 3'd6, 5); xact(1, 3'd7, 2);
    xact(1, 3'd1, 8'h90);
    check("R7 max width", we_w, 6); check("R7 max delay", waits, 13);
    check("R3 large byte", cap_dout, 8'h90);

    // R6 reads
    fl_din = 8'hA5; xact(0, 3'd3, 0);
    check("R6 read byte", rd, 8'hA5); check("R6 re width", re_w, 6);
    fl_din = 8'h3C; xact(0, 3'd3, 0);
    check("R6 read byte 2", rd, 8'h3C);

    // R2 chip selects
    xact(1, 3'd0, 8'h05); #2; check("R2 chip0", fl_ce_n, 2'b10);
    xact(1, 3'd0, 8'h03); #2; check("R2 chip1", fl_ce_n, 2'b01);
    // R9 write protect
    xact(1, 3'd0, 8'h0F); #2; check("R9 wp on", fl_wp_n, 0);
    xact(1, 3'd0, 8'h07); #2; check("R9 wp off", fl_wp_n, 1);

    // R10 disabled controller
    xact(1, 3'd0, 8'h06);
    pulses = we_cnt;
    xact(1, 3'd1, 8'hFF);
    check("R10 ack delay", waits, 0);
    repeat (20) @(negedge clk);
    check("R10 no strobe", we_cnt, pulses);
    xact(1, 3'd0, 8'h07);

    // R8 ready/busy synchroniser depth
    @(negedge clk); fl_rb = 0;
    xact(0, 3'd4, 0); check("R8 one edge", rd[0], 1);
    xact(0, 3'd4, 0); check("R8 two edges", rd[0], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule